// File: doc/BRIEF.md
# Two-Crossing Stub Capture Stage

This block sits at the input of a sector trigger processor and captures the track-segment stubs presented at each beam-crossing strobe into a fixed array of slots. In two-crossing mode a stub is kept for one extra crossing. A stub that reaches the processor one crossing late because of a timing error can therefore still be combined with its partners from the crossing before. In single-crossing mode the array holds only the stubs of the latest crossing.

Each slot holds a valid bit, a station number, an opaque payload and an age flag. The age flag tells whether the stub belongs to the latest crossing or to the one before it. Stubs of a crossing are packed into the free slots in lane order. When older stubs are still held, newer stubs may only use the slots those older stubs leave empty. A newer stub that repeats a held stub exactly is dropped, so one track cannot trigger twice. The array carries a 4-bit crossing tag, which names the earliest crossing that still has a stub in the array.

Top module: `stub_latch2x`

## Requirements
- R1: After reset every slot is empty (`slot_vld` all zero) and `bx_tag` is 0.
- R2: With `two_bx` = 0 (single-crossing), a strobe empties every slot and then loads that crossing's valid stubs with age flag 0.
- R3: With `two_bx` = 1, a slot holding an age-0 stub at a strobe keeps its station and payload, stays valid and gets age flag 1. A slot holding an age-1 stub at a strobe is released.
- R4: Stubs arriving at a strobe use only slots not kept under R3. Valid stubs beyond the number of free slots are dropped, and kept slots are never overwritten.
- R5: In two-crossing mode, an incoming stub whose station and payload both equal those of a kept slot is not stored.
- R6: The crossing number of a strobe is the count of earlier strobes since reset, modulo 16. After a strobe, `bx_tag` is the previous strobe's number if any slot was kept, and the current number otherwise.
- R7: Without a strobe, slot contents and `bx_tag` do not change, whatever the input lanes carry.
- R8: Admitted stubs go to free slots in ascending slot order, in ascending lane order. Lane l carries its station in `in_stn[2l+1:2l]` and its payload in `in_dat[8l+7:8l]`. Slot s is reported on the same bit positions of `slot_stn` and `slot_dat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_stb | input | 1 | Crossing strobe; lanes are sampled in this cycle |
| two_bx | input | 1 | 1 = two-crossing holding, 0 = single-crossing |
| in_vld | input | 16 | Per-lane stub valid |
| in_stn | input | 32 | Per-lane station number, 2 bits per lane |
| in_dat | input | 128 | Per-lane payload, 8 bits per lane |
| slot_vld | output | 15 | Per-slot valid |
| slot_age | output | 15 | Per-slot age flag, 1 = from previous crossing |
| slot_stn | output | 30 | Per-slot station number |
| slot_dat | output | 120 | Per-slot payload |
| bx_tag | output | 4 | Crossing number of the earliest stub held |

## Verification
The bench sends a late crossing whose stubs mix an exact repeat of a held stub with a near-repeat that differs only in station. A design that compares payload alone would drop the near-repeat, and one that skips the comparison would store the repeat. It fills all fifteen slots from sixteen lanes and then strobes again. A design without occupancy limiting would either overwrite held stubs or keep the sixteenth lane. The tag is checked through the hold, the release and the empty crossings that follow, which exposes a tag that follows the latest strobe or releases stubs a crossing early or late.

// File: rtl/stub_latch_pkg.sv
package stub_latch_pkg;
   typedef enum logic {
      LATCH_ONE = 1'b0,
      LATCH_TWO = 1'b1
   } latch_mode_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/stub_keep_mask.sv
module stub_keep_mask #(
   parameter int NSLOT = 15
) (
   input  logic             two_bx,
   input  logic [NSLOT-1:0] vld_q,
   input  logic [NSLOT-1:0] age_q,
   output logic [NSLOT-1:0] keep,
   output logic             any_keep
);
   import stub_latch_pkg::*;
   latch_mode_e mode;

   assign mode     = latch_mode_e'(two_bx);
   assign keep     = (mode == LATCH_TWO) ? (vld_q & ~age_q) : '0;
   assign any_keep = |keep;
endmodule

// File: rtl/stub_dup_filter.sv
module stub_dup_filter #(
   parameter int NSLOT = 15,
   parameter int NIN   = 16,
   parameter int STN_W = 2,
   parameter int DAT_W = 8
) (
   input  logic [NSLOT-1:0]            keep,
   input  logic [NSLOT-1:0][STN_W-1:0] stn_q,
   input  logic [NSLOT-1:0][DAT_W-1:0] dat_q,
   input  logic [NIN-1:0][STN_W-1:0]   lane_stn,
   input  logic [NIN-1:0][DAT_W-1:0]   lane_dat,
   output logic [NIN-1:0]              dup
);
   for (genvar l = 0; l < NIN; l++) begin : g_lane
      logic [NSLOT-1:0] hit;
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign hit[s] = keep[s] && (stn_q[s] == lane_stn[l]) && (dat_q[s] == lane_dat[l]);
      end
      assign dup[l] = |hit;
   end
endmodule

// File: rtl/stub_slot_alloc.sv
module stub_slot_alloc #(
   parameter int NSLOT = 15,
   parameter int NIN   = 16,
   localparam int SW   = stub_latch_pkg::idx_w(NSLOT),
   localparam int LW   = stub_latch_pkg::idx_w(NIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSLOT-1:0]        free,
   input  logic [NIN-1:0]          req,
   output logic [NSLOT-1:0]        fill,
   output logic [NSLOT-1:0][LW-1:0] fill_lane
);
   logic [NSLOT-1:0] avail;

   always_comb begin
      logic          found;
      logic [SW-1:0] pick;
      avail     = free;
      fill      = '0;
      fill_lane = '0;
      for (int l = 0; l < NIN; l++) begin
         found = 1'b0;
         pick  = '0;
         for (int s = 0; s < NSLOT; s++) begin
            if (!found && avail[s]) begin
               found = 1'b1;
               pick  = SW'(s);
            end
         end
         if (req[l] && found) begin
            avail[pick]     = 1'b0;
            fill[pick]      = 1'b1;
            fill_lane[pick] = LW'(l);
         end
      end
   end

   // R4: a slot is only ever granted when it was offered as free
   p_fill_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill & ~free) == '0);
   // R4: grants never exceed requests
   p_grant_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fill) <= $countones(req));
endmodule

// File: rtl/stub_latch2x.sv
module stub_latch2x #(
   parameter int NSLOT = 15,
   parameter int NIN   = 16,
   parameter int STN_W = 2,
   parameter int DAT_W = 8,
   parameter int TAG_W = 4,
   localparam int LW   = stub_latch_pkg::idx_w(NIN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bx_stb,
   input  logic                   two_bx,
   input  logic [NIN-1:0]         in_vld,
   input  logic [NIN*STN_W-1:0]   in_stn,
   input  logic [NIN*DAT_W-1:0]   in_dat,
   output logic [NSLOT-1:0]       slot_vld,
   output logic [NSLOT-1:0]       slot_age,
   output logic [NSLOT*STN_W-1:0] slot_stn,
   output logic [NSLOT*DAT_W-1:0] slot_dat,
   output logic [TAG_W-1:0]       bx_tag
);
   if (NSLOT < 1 || NIN < 1 || STN_W < 1 || DAT_W < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("stub_latch2x: every size parameter must be at least 1");
   end

   logic [NIN-1:0][STN_W-1:0]   lane_stn;
   logic [NIN-1:0][DAT_W-1:0]   lane_dat;
   logic [NSLOT-1:0]            vld_q, age_q, keep, fill;
   logic [NSLOT-1:0][STN_W-1:0] stn_q;
   logic [NSLOT-1:0][DAT_W-1:0] dat_q;
   logic [NSLOT-1:0][LW-1:0]    fill_lane;
   logic [NIN-1:0]              dup;
   logic                        any_keep;
   logic [TAG_W-1:0]            cnt_q, tag_q;

   assign lane_stn = in_stn;
   assign lane_dat = in_dat;

   stub_keep_mask #(.NSLOT(NSLOT)) u_keep (
      .two_bx(two_bx), .vld_q(vld_q), .age_q(age_q), .keep(keep), .any_keep(any_keep));

   stub_dup_filter #(.NSLOT(NSLOT), .NIN(NIN), .STN_W(STN_W), .DAT_W(DAT_W)) u_dup (
      .keep(keep), .stn_q(stn_q), .dat_q(dat_q),
      .lane_stn(lane_stn), .lane_dat(lane_dat), .dup(dup));

   stub_slot_alloc #(.NSLOT(NSLOT), .NIN(NIN)) u_alloc (
      .clk(clk), .rst_n(rst_n), .free(~keep), .req(in_vld & ~dup),
      .fill(fill), .fill_lane(fill_lane));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         age_q <= '0;
         stn_q <= '0;
         dat_q <= '0;
         cnt_q <= '0;
         tag_q <= '0;
      end else if (bx_stb) begin
         for (int s = 0; s < NSLOT; s++) begin
            if (keep[s]) begin
               vld_q[s] <= 1'b1;
               age_q[s] <= 1'b1;
            end else if (fill[s]) begin
               vld_q[s] <= 1'b1;
               age_q[s] <= 1'b0;
               stn_q[s] <= lane_stn[fill_lane[s]];
               dat_q[s] <= lane_dat[fill_lane[s]];
            end else begin
               vld_q[s] <= 1'b0;
               age_q[s] <= 1'b0;
            end
         end
         tag_q <= any_keep ? (cnt_q - TAG_W'(1)) : cnt_q;
         cnt_q <= cnt_q + TAG_W'(1);
      end
   end

   assign slot_vld = vld_q;
   assign slot_age = age_q;
   assign slot_stn = stn_q;
   assign slot_dat = dat_q;
   assign bx_tag   = tag_q;

   // R7: nothing moves between strobes
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_stb |=> ($stable(vld_q) && $stable(age_q) && $stable(tag_q)));
   // R2: single-crossing mode leaves only fresh stubs
   p_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_stb && !two_bx) |=> (age_q == '0));
   // R6: a kept stub pins the tag to the previous crossing
   p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_stb && any_keep) |=> (tag_q == $past(cnt_q) - TAG_W'(1)));

   for (genvar s = 0; s < NSLOT; s++) begin : g_chk
      logic [NSLOT-1:0] clash;
      for (genvar t = 0; t < NSLOT; t++) begin : g_pair
         assign clash[t] = vld_q[s] && !age_q[s] && vld_q[t] && age_q[t] &&
                           (stn_q[s] == stn_q[t]) && (dat_q[s] == dat_q[t]);
      end
      // R3: a fresh stub survives one strobe unchanged
      p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (bx_stb && two_bx && vld_q[s] && !age_q[s]) |=>
            (vld_q[s] && age_q[s] && $stable(stn_q[s]) && $stable(dat_q[s])));
      // R3: an aged stub never survives a strobe
      p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (bx_stb && vld_q[s] && age_q[s]) |=> !age_q[s]);
      // R5: no fresh stub repeats a held one
      p_nodup_r5: assert property (@(posedge clk) disable iff (!rst_n)
         clash == '0);
   end
endmodule

// File: tb/stub_latch2x_test.sv
module stub_latch2x_test;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 15;
   localparam int NI = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bx_stb = 1'b0;
   logic          two_bx = 1'b0;
   logic [NI-1:0] in_vld = '0;
   logic [NI*2-1:0] in_stn = '0;
   logic [NI*8-1:0] in_dat = '0;
   logic [NS-1:0] slot_vld, slot_age;
   logic [NS*2-1:0] slot_stn;
   logic [NS*8-1:0] slot_dat;
   logic [3:0]    bx_tag;

   int checks = 0;
   int failures = 0;
   int xcnt = 0;
   int last_nr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stub_latch2x uut (
      .clk(clk), .rst_n(rst_n), .bx_stb(bx_stb), .two_bx(two_bx),
      .in_vld(in_vld), .in_stn(in_stn), .in_dat(in_dat),
      .slot_vld(slot_vld), .slot_age(slot_age), .slot_stn(slot_stn),
      .slot_dat(slot_dat), .bx_tag(bx_tag));

   task automatic set_lane(int l, logic [1:0] st, logic [7:0] d);
      in_vld[l] = 1'b1;
      in_stn[l*2 +: 2] = st;
      in_dat[l*8 +: 8] = d;
   endtask

   task automatic strobe();
      @(negedge clk);
      bx_stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bx_stb = 1'b0;
      in_vld = '0;
      in_stn = '0;
      in_dat = '0;
      last_nr = xcnt;
      xcnt++;
   endtask

   task automatic chk_mask(logic [NS-1:0] ev, string rq);
      checks++;
      if (slot_vld !== ev) begin
         failures++;
         $display("FAIL %s slot_vld actual=%h expected=%h", rq, slot_vld, ev);
      end
   endtask

   task automatic chk_tag(int nr, string rq);
      checks++;
      if (bx_tag !== 4'(nr)) begin
         failures++;
         $display("FAIL %s bx_tag actual=%0d expected=%0d", rq, bx_tag, 4'(nr));
      end
   endtask

   task automatic chk_slot(int s, logic ea, logic [1:0] es, logic [7:0] ed, string rq);
      checks++;
      if (slot_vld[s] !== 1'b1 || slot_age[s] !== ea ||
          slot_stn[s*2 +: 2] !== es || slot_dat[s*8 +: 8] !== ed) begin
         failures++;
         $display("FAIL %s slot%0d actual v=%b a=%b st=%0d d=%h expected v=1 a=%b st=%0d d=%h",
                  rq, s, slot_vld[s], slot_age[s], slot_stn[s*2 +: 2], slot_dat[s*8 +: 8],
                  ea, es, ed);
      end
   endtask

   task automatic t_reset();
      chk_mask('0, "R1");
      chk_tag(0, "R1");
   endtask

   task automatic t_single();
      int n;
      two_bx = 1'b0;
      set_lane(1, 2'd0, 8'hA1);
      set_lane(4, 2'd1, 8'hB2);
      set_lane(9, 2'd3, 8'hC3);
      strobe();
      n = last_nr;
      chk_mask(15'h0007, "R2");
      chk_slot(0, 1'b0, 2'd0, 8'hA1, "R8");
      chk_slot(1, 1'b0, 2'd1, 8'hB2, "R8");
      chk_slot(2, 1'b0, 2'd3, 8'hC3, "R2");
      chk_tag(n, "R6");
      set_lane(0, 2'd2, 8'h55);
      strobe();
      chk_mask(15'h0001, "R2");
      chk_slot(0, 1'b0, 2'd2, 8'h55, "R2");
      chk_tag(last_nr, "R6");
   endtask

   task automatic t_hold();
      logic [NS-1:0] v0;
      logic [3:0] t0;
      v0 = slot_vld;
      t0 = bx_tag;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         in_vld = NI'(16'hFFFF >> k);
         in_dat = {NI{8'(k * 17)}};
         two_bx = k[0];
      end
      @(negedge clk);
      chk_mask(v0, "R7");
      checks++;
      if (bx_tag !== t0) begin
         failures++;
         $display("FAIL R7 bx_tag actual=%0d expected=%0d", bx_tag, t0);
      end
      chk_slot(0, 1'b0, 2'd2, 8'h55, "R7");
      in_vld = '0;
      in_dat = '0;
      two_bx = 1'b0;
   endtask

   task automatic t_two();
      int na, nb;
      two_bx = 1'b0;
      strobe();
      two_bx = 1'b1;
      set_lane(0, 2'd0, 8'h10);
      set_lane(1, 2'd1, 8'h11);
      set_lane(2, 2'd2, 8'h12);
      strobe();
      na = last_nr;
      chk_mask(15'h0007, "R3");
      chk_tag(na, "R6");
      set_lane(0, 2'd1, 8'h11);
      set_lane(1, 2'd3, 8'h20);
      set_lane(2, 2'd1, 8'h12);
      strobe();
      nb = last_nr;
      chk_mask(15'h001F, "R5");
      chk_slot(0, 1'b1, 2'd0, 8'h10, "R3");
      chk_slot(1, 1'b1, 2'd1, 8'h11, "R3");
      chk_slot(2, 1'b1, 2'd2, 8'h12, "R3");
      chk_slot(3, 1'b0, 2'd3, 8'h20, "R5");
      chk_slot(4, 1'b0, 2'd1, 8'h12, "R5");
      chk_tag(na, "R6");
      strobe();
      chk_mask(15'h0018, "R3");
      chk_slot(3, 1'b1, 2'd3, 8'h20, "R3");
      chk_slot(4, 1'b1, 2'd1, 8'h12, "R3");
      chk_tag(nb, "R6");
      strobe();
      chk_mask('0, "R3");
      chk_tag(last_nr, "R6");
   endtask

   task automatic t_overflow();
      int ne;
      two_bx = 1'b0;
      strobe();
      two_bx = 1'b1;
      for (int l = 0; l < NI; l++) set_lane(l, 2'(l), 8'(8'h40 + l));
      strobe();
      ne = last_nr;
      chk_mask('1, "R4");
      chk_slot(0, 1'b0, 2'd0, 8'h40, "R8");
      chk_slot(14, 1'b0, 2'd2, 8'h4E, "R4");
      for (int l = 0; l < 4; l++) set_lane(l, 2'(l), 8'(8'h80 + l));
      strobe();
      chk_mask('1, "R4");
      checks++;
      if (slot_age !== '1) begin
         failures++;
         $display("FAIL R4 slot_age actual=%h expected=%h", slot_age, 15'h7FFF);
      end
      chk_slot(0, 1'b1, 2'd0, 8'h40, "R4");
      chk_slot(14, 1'b1, 2'd2, 8'h4E, "R4");
      chk_tag(ne, "R6");
      set_lane(5, 2'd1, 8'h90);
      set_lane(7, 2'd2, 8'h91);
      strobe();
      chk_mask(15'h0003, "R4");
      chk_slot(0, 1'b0, 2'd1, 8'h90, "R8");
      chk_slot(1, 1'b0, 2'd2, 8'h91, "R8");
      chk_tag(last_nr, "R6");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_hold();
      t_two();
      t_overflow();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule